// File: doc/BRIEF.md
# Multi-master doorbell interrupt unit

This block holds a bank of doorbells that bus masters use to notify one another. Each doorbell belongs to one receiving master. Any master may ring any doorbell by writing to its ring register. The write carries the sender's master ID on a sideband field. The receiver owns a grant mask, which decides which senders may actually raise its interrupt. Every attempt is logged in a raw vector indexed by sender ID. Accepted rings are logged in a pending vector. The receiver's interrupt line stays high for as long as any pending bit is set.

The unit has several independent write ports, so rings and clears from different masters can land in the same clock cycle. The raw and pending vectors are write-one-to-clear. A ring that arrives in the same cycle as a clear of the same bit survives the clear, so no notification is lost. Reads are combinational from a single read address.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every grant, raw and pending vector reads zero and every interrupt line is low.
- R2: Each doorbell d occupies the block at address d*0x100 (the doorbell index is taken from address bits [10:8], 8 doorbells). Inside that block the registers sit at these offsets: ring 0x0, grant 0x4, raw 0x8, pending 0xC. Any other offset inside the block, including an address with nonzero bits [1:0] or [7:4], is ignored on write and reads as zero. The ring register also reads as zero.
- R3: A write to a ring register with data bit 0 set, on a port whose master ID is m (5 bits, 0 to 31), sets bit m of that doorbell's raw vector. A ring write with data bit 0 clear changes nothing.
- R4: That ring also sets pending bit m, but only if bit m of the doorbell's grant vector was already set before the cycle of the ring. A grant write in the same cycle does not affect that ring.
- R5: A grant write replaces the whole 32-bit grant vector. When several ports write the same grant vector in one cycle, the highest-numbered port wins.
- R6: A write to a pending register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R7: A write to a raw register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R8: When a ring and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Interrupt line d is high exactly while doorbell d's pending vector is nonzero. The line changes in the same cycle as the pending register, so it rises on the first clock edge after an accepted ring.
- R10: Rings from different ports to the same doorbell in one cycle are all recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | NPORT | Write strobe for each port |
| wr_addr | input | NPORT*AW | Byte address for each port, with port p at bits [p*AW +: AW] |
| wr_data | input | NPORT*32 | Write data for each port |
| wr_mid | input | NPORT*5 | Sender master ID for each port |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | NDB | Level interrupt for each doorbell |

## Verification
Rings are driven with the sender's grant bit clear, with it set, and with data bit 0 clear. These three cases separate the raw log from the pending log and show whether the data bit gates the ring.

Clears are tried on one bit, on the last remaining bit, and together with a ring on the same bit or on a different bit. These cases tell exact write-one-to-clear behaviour apart from a wholesale clear, and show that a ring wins over a clear of the same bit.

Two-port cycles cover three more cases:
- two grant writes to the same doorbell, which exposes port priority;
- a grant write together with a ring, which shows which grant value the ring is checked against;
- two rings from the lowest and highest master IDs.

Writes and reads at the highest doorbell index and at unmapped offsets check the address decode.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int DBU_MASTERS  = 32;
  localparam int DBU_MID_W    = $clog2(DBU_MASTERS);
  localparam int DBU_BLK_LSB  = 8;

  typedef logic [DBU_MASTERS-1:0] dbu_vec_t;

  typedef enum logic [1:0] {
    REG_RING  = 2'd0,
    REG_GRANT = 2'd1,
    REG_RAW   = 2'd2,
    REG_PEND  = 2'd3
  } dbu_reg_e;

  function automatic dbu_vec_t dbu_sticky(input dbu_vec_t cur, input dbu_vec_t set,
                                          input dbu_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic dbu_vec_t dbu_onehot(input logic [DBU_MID_W-1:0] mid);
    dbu_vec_t v;
    v = '0;
    v[mid] = 1'b1;
    return v;
  endfunction

  function automatic logic dbu_off_ok(input logic [DBU_BLK_LSB-1:0] off);
    return (off[7:4] == 4'd0) && (off[1:0] == 2'd0);
  endfunction
endpackage

// File: rtl/dbu_port_merge.sv
module dbu_port_merge
  import dbu_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int AW    = 11,
  parameter int IDX   = 0
) (
  input  logic [NPORT-1:0]           wr_vld,
  input  logic [NPORT*AW-1:0]        wr_addr,
  input  logic [NPORT*32-1:0]        wr_data,
  input  logic [NPORT*DBU_MID_W-1:0] wr_mid,
  output dbu_vec_t                   ring_mask,
  output logic                       grant_we,
  output dbu_vec_t                   grant_val,
  output dbu_vec_t                   raw_clr,
  output dbu_vec_t                   pend_clr
);
  localparam int IW = AW - DBU_BLK_LSB;
  localparam logic [IW-1:0] MY_IDX = IW'(IDX);

  always_comb begin
    logic [AW-1:0]        a;
    logic [31:0]          d;
    logic [DBU_MID_W-1:0] m;
    logic                 hit;
    ring_mask = '0;
    grant_we  = 1'b0;
    grant_val = '0;
    raw_clr   = '0;
    pend_clr  = '0;
    for (int p = 0; p < NPORT; p++) begin
      a   = wr_addr[p*AW +: AW];
      d   = wr_data[p*32 +: 32];
      m   = wr_mid[p*DBU_MID_W +: DBU_MID_W];
      hit = wr_vld[p] && (a[AW-1:DBU_BLK_LSB] == MY_IDX) &&
            dbu_off_ok(a[DBU_BLK_LSB-1:0]);
      if (hit) begin
        case (dbu_reg_e'(a[3:2]))
          REG_RING:  if (d[0]) ring_mask = ring_mask | dbu_onehot(m);
          REG_GRANT: begin
            grant_we  = 1'b1;
            grant_val = d;
          end
          REG_RAW:   raw_clr  = raw_clr | d;
          REG_PEND:  pend_clr = pend_clr | d;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbu_cell.sv
module dbu_cell
  import dbu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dbu_vec_t ring_mask,
  input  logic     grant_we,
  input  dbu_vec_t grant_val,
  input  dbu_vec_t raw_clr,
  input  dbu_vec_t pend_clr,
  output dbu_vec_t grant_q,
  output dbu_vec_t raw_q,
  output dbu_vec_t pend_q,
  output logic     irq_o
);
  dbu_vec_t accepted;
  assign accepted = ring_mask & grant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      raw_q   <= '0;
      pend_q  <= '0;
    end else begin
      if (grant_we) grant_q <= grant_val;
      raw_q  <= dbu_sticky(raw_q, ring_mask, raw_clr);
      pend_q <= dbu_sticky(pend_q, accepted, pend_clr);
    end
  end

  assign irq_o = |pend_q;

  p_raw_logs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ring_mask) |=> ((raw_q & $past(ring_mask)) == $past(ring_mask)));

  p_pend_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((pend_q & ~$past(pend_q)) & ~$past(ring_mask & grant_q)) == '0));

  p_clear_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((~pend_q & $past(pend_q)) & ~$past(pend_clr)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ring_mask & grant_q & pend_clr)) |=>
      ((pend_q & $past(ring_mask & grant_q)) == $past(ring_mask & grant_q)));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(ring_mask & grant_q)));
endmodule

// File: rtl/dbu_rdmux.sv
module dbu_rdmux
  import dbu_pkg::*;
#(
  parameter int NDB = 8,
  parameter int AW  = 11
) (
  input  logic [AW-1:0]              rd_addr,
  input  logic [NDB*DBU_MASTERS-1:0] grant_all,
  input  logic [NDB*DBU_MASTERS-1:0] raw_all,
  input  logic [NDB*DBU_MASTERS-1:0] pend_all,
  output logic [31:0]                rd_data
);
  localparam int IW = AW - DBU_BLK_LSB;

  always_comb begin
    logic [IW-1:0] idx;
    idx     = rd_addr[AW-1:DBU_BLK_LSB];
    rd_data = '0;
    for (int d = 0; d < NDB; d++) begin
      if ((idx == IW'(d)) && dbu_off_ok(rd_addr[DBU_BLK_LSB-1:0])) begin
        case (dbu_reg_e'(rd_addr[3:2]))
          REG_GRANT: rd_data = grant_all[d*DBU_MASTERS +: DBU_MASTERS];
          REG_RAW:   rd_data = raw_all[d*DBU_MASTERS +: DBU_MASTERS];
          REG_PEND:  rd_data = pend_all[d*DBU_MASTERS +: DBU_MASTERS];
          default:   rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import dbu_pkg::*;
#(
  parameter int NDB   = 8,
  parameter int NPORT = 2,
  parameter int AW    = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           wr_vld,
  input  logic [NPORT*AW-1:0]        wr_addr,
  input  logic [NPORT*32-1:0]        wr_data,
  input  logic [NPORT*DBU_MID_W-1:0] wr_mid,
  input  logic [AW-1:0]              rd_addr,
  output logic [31:0]                rd_data,
  output logic [NDB-1:0]             irq
);
  logic [NDB*DBU_MASTERS-1:0] grant_all;
  logic [NDB*DBU_MASTERS-1:0] raw_all;
  logic [NDB*DBU_MASTERS-1:0] pend_all;

  for (genvar d = 0; d < NDB; d++) begin : g_db
    dbu_vec_t ring_mask, grant_val, raw_clr, pend_clr;
    dbu_vec_t grant_q, raw_q, pend_q;
    logic     grant_we;

    dbu_port_merge #(.NPORT(NPORT), .AW(AW), .IDX(d)) u_merge (
      .wr_vld   (wr_vld),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_mid   (wr_mid),
      .ring_mask(ring_mask),
      .grant_we (grant_we),
      .grant_val(grant_val),
      .raw_clr  (raw_clr),
      .pend_clr (pend_clr)
    );

    dbu_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .ring_mask(ring_mask),
      .grant_we (grant_we),
      .grant_val(grant_val),
      .raw_clr  (raw_clr),
      .pend_clr (pend_clr),
      .grant_q  (grant_q),
      .raw_q    (raw_q),
      .pend_q   (pend_q),
      .irq_o    (irq[d])
    );

    assign grant_all[d*DBU_MASTERS +: DBU_MASTERS] = grant_q;
    assign raw_all[d*DBU_MASTERS +: DBU_MASTERS]   = raw_q;
    assign pend_all[d*DBU_MASTERS +: DBU_MASTERS]  = pend_q;
  end

  dbu_rdmux #(.NDB(NDB), .AW(AW)) u_rdmux (
    .rd_addr  (rd_addr),
    .grant_all(grant_all),
    .raw_all  (raw_all),
    .pend_all (pend_all),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  vld = '0;
  logic [AW-1:0] a0 = '0, a1 = '0, rd_addr = '0;
  logic [31:0] d0 = '0, d1 = '0;
  logic [4:0]  m0 = '0, m1 = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_vld(vld),
    .wr_addr({a1, a0}), .wr_data({d1, d0}), .wr_mid({m1, m0}),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v0, input logic [AW-1:0] x0, input logic [31:0] y0,
                     input logic [4:0] z0, input bit v1, input logic [AW-1:0] x1,
                     input logic [31:0] y1, input logic [4:0] z1);
    @(negedge clk);
    vld = {v1, v0}; a0 = x0; d0 = y0; m0 = z0; a1 = x1; d1 = y1; m1 = z1;
    @(posedge clk);
    #1 vld = '0;
  endtask

  task automatic wr(input logic [AW-1:0] x, input logic [31:0] y, input logic [4:0] z);
    cyc(1'b1, x, y, z, 1'b0, '0, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] x, output logic [31:0] y);
    rd_addr = x;
    #1 y = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(11'h004, v); chk("R1 grant0", v, 0);
    rd(11'h708, v); chk("R1 raw7", v, 0);
    rd(11'h30C, v); chk("R1 pend3", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_denied;
    logic [31:0] v;
    wr(11'h200, 32'h1, 5'd5);
    rd(11'h208, v); chk("R3 raw logs denied ring", v, 32'h20);
    rd(11'h20C, v); chk("R4 denied not pending", v, 0);
    chk("R9 irq low when denied", 32'(irq), 0);
    wr(11'h200, 32'h2, 5'd6);
    rd(11'h208, v); chk("R3 zero data bit ignored", v, 32'h20);
  endtask

  task automatic t_allowed;
    logic [31:0] v;
    wr(11'h204, 32'h140, 5'd0);
    rd(11'h204, v); chk("R5 grant write", v, 32'h140);
    wr(11'h200, 32'h1, 5'd6);
    rd(11'h20C, v); chk("R4 granted pending", v, 32'h40);
    rd(11'h208, v); chk("R3 raw accum", v, 32'h60);
    chk("R9 irq high", 32'(irq), 32'h04);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(11'h200, 32'h1, 5'd8);
    rd(11'h20C, v); chk("R4 second ring", v, 32'h140);
    wr(11'h20C, 32'h40, 5'd0);
    rd(11'h20C, v); chk("R6 partial clear", v, 32'h100);
    chk("R9 irq stays", 32'(irq), 32'h04);
    wr(11'h20C, 32'h100, 5'd0);
    rd(11'h20C, v); chk("R6 full clear", v, 0);
    chk("R9 irq drops", 32'(irq), 0);
    wr(11'h208, 32'h20, 5'd0);
    rd(11'h208, v); chk("R7 raw clear", v, 32'h140);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    wr(11'h200, 32'h1, 5'd6);
    cyc(1'b1, 11'h200, 32'h1, 5'd6, 1'b1, 11'h20C, 32'h40, 5'd1);
    rd(11'h20C, v); chk("R8 ring beats clear", v, 32'h40);
    cyc(1'b1, 11'h200, 32'h1, 5'd8, 1'b1, 11'h20C, 32'h40, 5'd1);
    rd(11'h20C, v); chk("R8 other bit cleared", v, 32'h100);
    wr(11'h20C, 32'hFFFF_FFFF, 5'd0);
    rd(11'h20C, v); chk("R6 clear all", v, 0);
  endtask

  task automatic t_grant;
    logic [31:0] v;
    cyc(1'b1, 11'h304, 32'hA, 5'd0, 1'b1, 11'h304, 32'h5, 5'd1);
    rd(11'h304, v); chk("R5 higher port wins", v, 32'h5);
    cyc(1'b1, 11'h200, 32'h1, 5'd7, 1'b1, 11'h204, 32'h80, 5'd1);
    rd(11'h20C, v); chk("R4 old grant used", v, 0);
    rd(11'h204, v); chk("R5 grant replaced", v, 32'h80);
  endtask

  task automatic t_dual;
    logic [31:0] v;
    wr(11'h404, 32'hFFFF_FFFF, 5'd0);
    cyc(1'b1, 11'h400, 32'h1, 5'd31, 1'b1, 11'h400, 32'h1, 5'd0);
    rd(11'h40C, v); chk("R10 both rings", v, 32'h8000_0001);
    chk("R9 irq4 only", 32'(irq), 32'h10);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(11'h704, 32'h8, 5'd0);
    wr(11'h700, 32'h1, 5'd3);
    rd(11'h70C, v); chk("R2 top doorbell pending", v, 32'h8);
    rd(11'h700, v); chk("R2 ring reads zero", v, 0);
    wr(11'h214, 32'hFFFF_FFFF, 5'd0);
    wr(11'h205, 32'hFFFF_FFFF, 5'd0);
    rd(11'h204, v); chk("R2 unmapped writes ignored", v, 32'h80);
    rd(11'h714, v); chk("R2 unmapped reads zero", v, 0);
    chk("R9 irq set", 32'(irq), 32'h90);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_denied();
    t_allowed();
    t_clear();
    t_set_wins();
    t_grant();
    t_dual();
    t_decode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule